// File: doc/BRIEF.md
# Bus-Inactivity Power-Down Gate

This block sits between an 8-bit microcontroller bus and the on-chip memories and logic arrays. It watches the address strobe for activity. When the strobe has not changed for a programmable number of clock cycles, and automatic power-down is enabled, the block enters a low-power state. In that state it freezes the address and data lines that reach the memories and logic arrays at their last values, and it forces every memory select inactive. Any change on the strobe wakes the block on the next clock.

The CPU writes a few mode registers through a small write port. The control register holds a turbo-disable flag, the power-down enable and the 4-bit idle limit. The other registers hold one blocking bit for each address line. A set bit freezes that line, as seen by the logic arrays, at its value before the bit was set. A separate active-low chip-select input turns the memory selects off without freezing any bus signal.

Top module: `bus_idle_pwrdn`

## Requirements
- R1: Register 0 holds the idle limit L in bits [7:4]. A strobe change (either level transition) is registered at a clock edge E0 and reloads the idle count. If there is no further change, `powerDown` becomes 1 right after the edge that falls L+1 cycles after E0.
- R2: While register 0 bit 1 (enable) is 0, `powerDown` never rises from 0. It rises only through R1.
- R3: While `powerDown` is 1, `memAddr`, `memData` and `logicIn` keep the values that `busAddr` and `busData` had at the entry edge, whatever the bus does.
- R4: While `powerDown` is 1, `memSel` is all zeros.
- R5: When `chipSelN` is 1, `memSel` is all zeros. `memAddr` and `logicIn` still follow `busAddr` combinationally.
- R6: Registers 1 and 2 are blocking masks for `logicIn` bits [7:0] and [15:8]. A set bit holds that `logicIn` bit at the value it had when the bit was set. Clear bits follow `busAddr`.
- R7: `turboOff` mirrors register 0 bit 0. It is 0 after reset.
- R8: A strobe change while powered down clears `powerDown` after the next clock edge. The idle count restarts from that edge.
- R9: Register writes take effect while `powerDown` is 1, and they do not change `powerDown`.
- R10: After reset, `powerDown` is 0, all mode registers are 0, `memSel` equals `selReq` while `chipSelN` is 0, and the bus passes straight through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addrStrobe | input | 1 | Address strobe from the CPU bus |
| busAddr | input | 16 | CPU address bus |
| busData | input | 8 | CPU data bus |
| selReq | input | 4 | Memory selects requested by address decode |
| chipSelN | input | 1 | Active-low chip select; when high, the memory selects are forced off |
| regWrEn | input | 1 | Mode register write strobe |
| regAddr | input | 2 | Mode register index |
| regWrData | input | 8 | Mode register write data |
| memAddr | output | 16 | Address to the memories, frozen in power-down |
| memData | output | 8 | Data to the memories, frozen in power-down |
| memSel | output | 4 | Memory selects after power-down and chip-select gating |
| logicIn | output | 16 | Address lines to the logic arrays after blocking and freezing |
| turboOff | output | 1 | Turbo-disable flag |
| powerDown | output | 1 | High while powered down |

## Verification
The assertions check, on every cycle, that the selects stay off under power-down or a deasserted chip select, and that the frozen bus and blocked logic lines stay stable. They also check that a disabled block never enters power-down and that any strobe change wakes it on the following clock. Only the bench scenarios can show the exact entry cycle for each idle limit, including zero and the saturated maximum. The same holds for which values get captured on entry or when a mask bit is set, and for register writes landing during power-down.

// File: rtl/idle_pd_pkg.sv
package idle_pd_pkg;
  localparam int REG_W      = 8;
  localparam int TURBO_BIT  = 0;
  localparam int ENABLE_BIT = 1;
  localparam int LIMIT_LSB  = 4;

  typedef struct packed {
    logic gateBus;
    logic killSel;
  } pdStrobes_t;
endpackage

// File: rtl/idle_pd_regs.sv
module idle_pd_regs
  import idle_pd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 4,
  parameter int REG_AW = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic              turboOff,
  output logic              pdEnable,
  output logic [CNT_W-1:0]  idleLimit,
  output logic [ADDR_W-1:0] blockMask
);
  localparam int NUM_MASK = (ADDR_W + REG_W - 1) / REG_W;

  logic                      turboQ;
  logic                      enableQ;
  logic [CNT_W-1:0]          limitQ;
  logic [NUM_MASK*REG_W-1:0] maskFlat;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      turboQ  <= 1'b0;
      enableQ <= 1'b0;
      limitQ  <= '0;
    end else if (regWrEn && regAddr == '0) begin
      turboQ  <= regWrData[TURBO_BIT];
      enableQ <= regWrData[ENABLE_BIT];
      limitQ  <= regWrData[LIMIT_LSB +: CNT_W];
    end
  end

  for (genvar g = 0; g < NUM_MASK; g++) begin : g_mask
    always_ff @(posedge clk) begin
      if (!rstN) begin
        maskFlat[g*REG_W +: REG_W] <= '0;
      end else if (regWrEn && regAddr == REG_AW'(g + 1)) begin
        maskFlat[g*REG_W +: REG_W] <= regWrData;
      end
    end
  end

  assign turboOff  = turboQ;
  assign pdEnable  = enableQ;
  assign idleLimit = limitQ;
  assign blockMask = maskFlat[ADDR_W-1:0];
endmodule

// File: rtl/idle_pd_ctrl.sv
module idle_pd_ctrl
  import idle_pd_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             addrStrobe,
  input  logic             pdEnable,
  input  logic [CNT_W-1:0] idleLimit,
  output pdStrobes_t       strobes,
  output logic             powerDown
);
  logic             asPrev;
  logic             strobeEdge;
  logic [CNT_W-1:0] idleCnt;
  logic             pdQ;
  logic             pdNext;

  assign strobeEdge = addrStrobe ^ asPrev;

  always_comb begin
    if (strobeEdge)   pdNext = 1'b0;
    else if (pdQ)     pdNext = 1'b1;
    else              pdNext = pdEnable && (idleCnt >= idleLimit);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      asPrev  <= 1'b0;
      idleCnt <= '0;
      pdQ     <= 1'b0;
    end else begin
      asPrev <= addrStrobe;
      if (strobeEdge)           idleCnt <= '0;
      else if (idleCnt != '1)   idleCnt <= idleCnt + 1'b1;
      pdQ <= pdNext;
    end
  end

  assign strobes.gateBus = pdQ;
  assign strobes.killSel = pdQ;
  assign powerDown       = pdQ;
endmodule

// File: rtl/idle_pd_path.sv
module idle_pd_path
  import idle_pd_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int NUM_SEL = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  pdStrobes_t         strobes,
  input  logic               chipSelN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busData,
  input  logic [NUM_SEL-1:0] selReq,
  input  logic [ADDR_W-1:0]  blockMask,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [DATA_W-1:0]  memData,
  output logic [NUM_SEL-1:0] memSel,
  output logic [ADDR_W-1:0]  logicIn
);
  logic [ADDR_W-1:0] addrHold;
  logic [DATA_W-1:0] dataHold;
  logic [ADDR_W-1:0] logicHold;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrHold <= '0;
      dataHold <= '0;
    end else if (!strobes.gateBus) begin
      addrHold <= busAddr;
      dataHold <= busData;
    end
  end

  assign memAddr = strobes.gateBus ? addrHold : busAddr;
  assign memData = strobes.gateBus ? dataHold : busData;
  assign memSel  = (strobes.killSel || chipSelN) ? '0 : selReq;

  for (genvar i = 0; i < ADDR_W; i++) begin : g_logic
    logic freeze;
    assign freeze = strobes.gateBus || blockMask[i];
    always_ff @(posedge clk) begin
      if (!rstN)        logicHold[i] <= 1'b0;
      else if (!freeze) logicHold[i] <= busAddr[i];
    end
    assign logicIn[i] = freeze ? logicHold[i] : busAddr[i];
  end
endmodule

// File: rtl/bus_idle_pwrdn.sv
module bus_idle_pwrdn
  import idle_pd_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int NUM_SEL = 4,
  parameter int CNT_W   = 4,
  parameter int REG_AW  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               addrStrobe,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busData,
  input  logic [NUM_SEL-1:0] selReq,
  input  logic               chipSelN,
  input  logic               regWrEn,
  input  logic [REG_AW-1:0]  regAddr,
  input  logic [REG_W-1:0]   regWrData,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [DATA_W-1:0]  memData,
  output logic [NUM_SEL-1:0] memSel,
  output logic [ADDR_W-1:0]  logicIn,
  output logic               turboOff,
  output logic               powerDown
);
  logic              pdEnable;
  logic [CNT_W-1:0]  idleLimit;
  logic [ADDR_W-1:0] blockMask;
  pdStrobes_t        strobes;

  idle_pd_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_AW(REG_AW)) regs_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .turboOff(turboOff), .pdEnable(pdEnable),
    .idleLimit(idleLimit), .blockMask(blockMask)
  );

  idle_pd_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .addrStrobe(addrStrobe), .pdEnable(pdEnable),
    .idleLimit(idleLimit), .strobes(strobes), .powerDown(powerDown)
  );

  idle_pd_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SEL(NUM_SEL)) path_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .chipSelN(chipSelN),
    .busAddr(busAddr), .busData(busData), .selReq(selReq),
    .blockMask(blockMask), .memAddr(memAddr), .memData(memData),
    .memSel(memSel), .logicIn(logicIn)
  );
endmodule

// File: rtl/idle_pd_checker.sv
module idle_pd_checker #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int NUM_SEL = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               addrStrobe,
  input logic               chipSelN,
  input logic               powerDown,
  input logic               pdEnable,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [ADDR_W-1:0]  memAddr,
  input logic [DATA_W-1:0]  memData,
  input logic [NUM_SEL-1:0] memSel,
  input logic [ADDR_W-1:0]  logicIn,
  input logic [ADDR_W-1:0]  blockMask
);
  a_r4_sel_off_in_pd: assert property (@(posedge clk) disable iff (!rstN)
    powerDown |-> memSel == '0);

  a_r5_cs_deselects: assert property (@(posedge clk) disable iff (!rstN)
    chipSelN |-> memSel == '0);

  a_r5_cs_no_gating: assert property (@(posedge clk) disable iff (!rstN)
    (chipSelN && !powerDown) |-> (memAddr == busAddr));

  a_r3_frozen_bus: assert property (@(posedge clk) disable iff (!rstN)
    (powerDown && $past(powerDown)) |->
      ($stable(memAddr) && $stable(memData) && $stable(logicIn)));

  a_r2_no_entry_disabled: assert property (@(posedge clk) disable iff (!rstN)
    (!pdEnable && !powerDown) |=> !powerDown);

  a_r8_wake_on_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (powerDown && ($rose(addrStrobe) || $fell(addrStrobe))) |=> !powerDown);

  for (genvar i = 0; i < ADDR_W; i++) begin : g_blk
    a_r6_blocked_stable: assert property (@(posedge clk) disable iff (!rstN)
      (blockMask[i] && $past(blockMask[i])) |-> $stable(logicIn[i]));
  end
endmodule

bind bus_idle_pwrdn idle_pd_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SEL(NUM_SEL)
) chk_i (
  .clk(clk), .rstN(rstN), .addrStrobe(addrStrobe), .chipSelN(chipSelN),
  .powerDown(powerDown), .pdEnable(pdEnable), .busAddr(busAddr),
  .memAddr(memAddr), .memData(memData), .memSel(memSel),
  .logicIn(logicIn), .blockMask(blockMask)
);

// File: tb/bus_idle_pwrdn_tb_top.sv
module bus_idle_pwrdn_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        addrStrobe = 1'b0;
  logic [15:0] busAddr = '0;
  logic [7:0]  busData = '0;
  logic [3:0]  selReq = 4'b1010;
  logic        chipSelN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [7:0]  regWrData = '0;
  logic [15:0] memAddr;
  logic [7:0]  memData;
  logic [3:0]  memSel;
  logic [15:0] logicIn;
  logic        turboOff;
  logic        powerDown;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bus_idle_pwrdn dut_i (
    .clk(clk), .rstN(rstN), .addrStrobe(addrStrobe), .busAddr(busAddr),
    .busData(busData), .selReq(selReq), .chipSelN(chipSelN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .memAddr(memAddr), .memData(memData), .memSel(memSel),
    .logicIn(logicIn), .turboOff(turboOff), .powerDown(powerDown)
  );

  typedef struct packed {
    logic [3:0] lim;
    logic       en;
    logic [4:0] waitN;
    logic       expPd;
  } vec_t;

  // entry cycle per R1 / R2: expPd = en && waitN >= lim+1
  localparam vec_t VECS [9] = '{
    '{4'd3,  1'b1, 5'd3,  1'b0},
    '{4'd3,  1'b1, 5'd4,  1'b1},
    '{4'd0,  1'b1, 5'd0,  1'b0},
    '{4'd0,  1'b1, 5'd1,  1'b1},
    '{4'd5,  1'b0, 5'd20, 1'b0},
    '{4'd15, 1'b1, 5'd15, 1'b0},
    '{4'd15, 1'b1, 5'd16, 1'b1},
    '{4'd7,  1'b1, 5'd8,  1'b1},
    '{4'd7,  1'b0, 5'd12, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic toggleStrobe();
    @(negedge clk);
    addrStrobe = ~addrStrobe;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    busAddr = 16'h1357; busData = 8'h24;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R10 powerDown reset", powerDown, 0);
    chk("R7 turboOff reset", turboOff, 0);
    chk("R10 memSel pass", memSel, 4'b1010);
    chk("R10 memAddr pass", memAddr, 16'h1357);
    chk("R10 logicIn pass", logicIn, 16'h1357);
    repeat (20) @(negedge clk);
    chk("R10 no entry with enable clear", powerDown, 0);

    writeReg(2'd0, 8'h01); #1;
    chk("R7 turboOff set", turboOff, 1);
    writeReg(2'd0, 8'h00); #1;
    chk("R7 turboOff clear", turboOff, 0);

    chipSelN = 1'b1; busAddr = 16'h2468; #1;
    chk("R5 memSel off", memSel, 0);
    chk("R5 memAddr follows", memAddr, 16'h2468);
    chk("R5 logicIn follows", logicIn, 16'h2468);
    @(negedge clk); chipSelN = 1'b0; #1;
    chk("R5 memSel back", memSel, 4'b1010);

    @(negedge clk); busAddr = 16'h00A5;
    writeReg(2'd1, 8'h0F);
    busAddr = 16'hFF5A; #1;
    chk("R6 low nibble held", logicIn, 16'hFF55);
    @(negedge clk); #1;
    chk("R6 still held", logicIn, 16'hFF55);
    writeReg(2'd1, 8'h00); #1;
    chk("R6 released", logicIn, 16'hFF5A);
    writeReg(2'd2, 8'h80);
    busAddr = 16'h7F5A; #1;
    chk("R6 high mask bit held", logicIn, 16'hFF5A);
    writeReg(2'd2, 8'h00);

    for (int k = 0; k < 9; k++) begin
      writeReg(2'd0, {VECS[k].lim, 2'b00, VECS[k].en, 1'b0});
      toggleStrobe();
      @(posedge clk);
      repeat (int'(VECS[k].waitN)) @(posedge clk);
      #1;
      chk($sformatf("R1 R2 vector %0d powerDown", k), powerDown, VECS[k].expPd);
    end

    writeReg(2'd0, 8'h22);
    busAddr = 16'h1234; busData = 8'h5A;
    toggleStrobe();
    @(posedge clk);
    repeat (3) @(posedge clk); #1;
    chk("R1 entered limit 2", powerDown, 1);
    @(negedge clk);
    busAddr = 16'hABCD; busData = 8'hC3; #1;
    chk("R3 memAddr frozen", memAddr, 16'h1234);
    chk("R3 memData frozen", memData, 8'h5A);
    chk("R3 logicIn frozen", logicIn, 16'h1234);
    chk("R4 memSel off", memSel, 0);

    writeReg(2'd0, 8'h23); #1;
    chk("R9 turbo write in pd", turboOff, 1);
    chk("R9 still powered down", powerDown, 1);

    toggleStrobe();
    @(posedge clk); #1;
    chk("R8 woke", powerDown, 0);
    chk("R8 memAddr live", memAddr, 16'hABCD);
    repeat (2) @(posedge clk); #1;
    chk("R8 count restarted", powerDown, 0);
    @(posedge clk); #1;
    chk("R8 re-entry", powerDown, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule